// File: doc/BRIEF.md
# Two-Clock Parity-Checked Block Memory

This block is a simple dual-port memory of 256 words, 9 bits each, with one port that only writes and one that only reads. Each port runs on its own clock. Bit 8 of a word is meant to hold a parity bit over bits 7:0. A single polarity input picks odd or even parity for both ports. The write port flags a word whose parity bit is wrong. The read port flags a word that comes out with bad parity.

A static mode input sets the read latency. In flow-through timing, the word appears right after the read-clock edge that captures the address. In pipelined timing, a second register stage holds the word back by one more read-clock edge, which leaves a full cycle for logic downstream. Sometimes a read and a write hit the same address at the same edge. In that case the read returns the word being written, not the old one; this holds when both ports share one clock.

Top module: `dual_clk_parity_ram`

## Requirements
- R1: A word is stored only when wr_sel_n and wr_stb_n are both 0 at a rising wr_clk edge. If either is 1, the word at that address keeps its old value, and a later read shows the old value.
- R2: A read access starts only when rd_sel_n and rd_stb_n are both 0 at a rising rd_clk edge. If no access starts, rd_data and rd_perr keep their previous values.
- R3: With pipe_mode = 0, the word at the captured read address is on rd_data just after the rd_clk edge that starts the access.
- R4: With pipe_mode = 1, the word is on rd_data just after the second rd_clk edge, counting the edge that starts the access as the first.
- R5: On each write, wr_perr is updated at that wr_clk edge and then held until the next write. Its value is the XOR of all 9 bits of wr_data, XORed with odd_sel. odd_sel = 1 selects odd parity and 0 selects even parity. The word is stored even when wr_perr is set.
- R6: rd_perr equals the XOR of the 9 bits of the word read, XORed with the odd_sel value at the access edge. It moves in step with rd_data in both latency modes.
- R7: A read and a write to the same address at the same edge return the incoming write data on the read port. This applies only when the two clocks are tied together.
- R8: With rst = 1 at a clock edge, the read output registers and rd_perr are cleared on rd_clk, and wr_perr is cleared on wr_clk. The stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| rst | input | 1 | Synchronous reset, active high, sampled by each clock |
| odd_sel | input | 1 | Parity polarity: 1 = odd, 0 = even |
| pipe_mode | input | 1 | Static read timing: 0 = flow-through, 1 = pipelined |
| wr_sel_n | input | 1 | Write block select, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| wr_addr | input | 8 | Write address |
| wr_data | input | 9 | Write data; bit 8 is parity |
| wr_perr | output | 1 | Write parity error flag |
| rd_sel_n | input | 1 | Read block select, active low |
| rd_stb_n | input | 1 | Read strobe, active low |
| rd_addr | input | 8 | Read address |
| rd_data | output | 9 | Read data; bit 8 is parity |
| rd_perr | output | 1 | Read parity error flag |

## Verification
The case hardest to reach is a read and a write that land on the same address at the same edge, while the bypass result still has to pass through the pipelined stage. Purely random addresses over 256 words make such collisions rare. For that reason the stimulus draws most addresses from a narrow window of eight words, and it toggles pipe_mode while traffic is flowing. Directed collisions are also issued in both latency modes. Blocked writes are then read back to confirm that the old word survived.

// File: rtl/dcpr_pkg.sv
`timescale 1ns/1ps
package dcpr_pkg;
    localparam int unsigned DCPR_ADDR_W = 8;
    localparam int unsigned DCPR_DATA_W = 9;

    typedef enum logic {
        LAT_ONE = 1'b0,
        LAT_TWO = 1'b1
    } rd_lat_e;
endpackage

// File: rtl/dcpr_parity.sv
`timescale 1ns/1ps
module dcpr_parity #(
    parameter int unsigned DW = 9
) (
    input  logic [DW-1:0] word,
    input  logic          odd_sel,
    output logic          err
);
    // The word is correct when the count of ones matches the selected polarity.
    logic [DW:0] chain;
    assign chain[0] = odd_sel;
    for (genvar i = 0; i < DW; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ word[i];
    end
    assign err = chain[DW];
endmodule

// File: rtl/dcpr_store.sv
`timescale 1ns/1ps
module dcpr_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 9
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/dcpr_rdpath.sv
`timescale 1ns/1ps
module dcpr_rdpath #(
    parameter int unsigned DW = 9
) (
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          bypass,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_word,
    input  logic          odd_sel,
    output logic [DW-1:0] s1_data,
    output logic          s1_perr
);
    logic [DW-1:0] next_word;
    logic          next_err;

    assign next_word = bypass ? wdata : mem_word;

    dcpr_parity #(.DW(DW)) u_rpar (
        .word    (next_word),
        .odd_sel (odd_sel),
        .err     (next_err)
    );

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            s1_data <= '0;
            s1_perr <= 1'b0;
        end else if (rd_en) begin
            s1_data <= next_word;
            s1_perr <= next_err;
        end
    end
endmodule

// File: rtl/dcpr_outreg.sv
`timescale 1ns/1ps
module dcpr_outreg #(
    parameter int unsigned DW = 9
) (
    input  logic          rd_clk,
    input  logic          rst,
    input  logic [DW-1:0] d,
    input  logic          perr_d,
    output logic [DW-1:0] q,
    output logic          perr_q
);
    always_ff @(posedge rd_clk) begin
        if (rst) begin
            q      <= '0;
            perr_q <= 1'b0;
        end else begin
            q      <= d;
            perr_q <= perr_d;
        end
    end
endmodule

// File: rtl/dual_clk_parity_ram.sv
`timescale 1ns/1ps
module dual_clk_parity_ram
    import dcpr_pkg::*;
#(
    parameter int unsigned AW = DCPR_ADDR_W,
    parameter int unsigned DW = DCPR_DATA_W
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          odd_sel,
    input  logic          pipe_mode,
    input  logic          wr_sel_n,
    input  logic          wr_stb_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_perr,
    input  logic          rd_sel_n,
    input  logic          rd_stb_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_perr
);
    logic          we;
    logic          rd_en;
    logic          bypass;
    logic [DW-1:0] mem_word;
    logic [DW-1:0] s1_data;
    logic          s1_perr;
    logic [DW-1:0] s2_data;
    logic          s2_perr;
    logic          wr_err_now;
    rd_lat_e       lat;

    assign we     = ~wr_sel_n & ~wr_stb_n;
    assign rd_en  = ~rd_sel_n & ~rd_stb_n;
    assign bypass = we && (wr_addr == rd_addr);
    assign lat    = rd_lat_e'(pipe_mode);

    dcpr_store #(.AW(AW), .DW(DW)) u_store (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr  (rd_addr),
        .rword  (mem_word)
    );

    dcpr_parity #(.DW(DW)) u_wpar (
        .word    (wr_data),
        .odd_sel (odd_sel),
        .err     (wr_err_now)
    );

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wr_perr <= 1'b0;
        end else if (we) begin
            wr_perr <= wr_err_now;
        end
    end

    dcpr_rdpath #(.DW(DW)) u_rdpath (
        .rd_clk   (rd_clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .bypass   (bypass),
        .wdata    (wr_data),
        .mem_word (mem_word),
        .odd_sel  (odd_sel),
        .s1_data  (s1_data),
        .s1_perr  (s1_perr)
    );

    dcpr_outreg #(.DW(DW)) u_outreg (
        .rd_clk (rd_clk),
        .rst    (rst),
        .d      (s1_data),
        .perr_d (s1_perr),
        .q      (s2_data),
        .perr_q (s2_perr)
    );

    always_comb begin
        unique case (lat)
            LAT_ONE: begin
                rd_data = s1_data;
                rd_perr = s1_perr;
            end
            LAT_TWO: begin
                rd_data = s2_data;
                rd_perr = s2_perr;
            end
            default: begin
                rd_data = s1_data;
                rd_perr = s1_perr;
            end
        endcase
    end
endmodule

// File: rtl/dcpr_checker.sv
`timescale 1ns/1ps
module dcpr_checker #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          odd_sel,
    input logic          pipe_mode,
    input logic          wr_sel_n,
    input logic          wr_stb_n,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_perr,
    input logic          rd_sel_n,
    input logic          rd_stb_n,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          rd_perr,
    input logic [DW-1:0] s1_data,
    input logic          s1_perr
);
    logic wr_go;
    logic rd_go;
    logic addr_seen;
    assign wr_go = ~wr_sel_n & ~wr_stb_n;
    assign rd_go = ~rd_sel_n & ~rd_stb_n;
    assign addr_seen = ^{wr_addr, rd_addr} | 1'b1;

    assert_reset_clear_rd_R8: assert property (@(posedge rd_clk)
        rst |=> (rd_data == '0) && !rd_perr);

    assert_reset_clear_wr_R8: assert property (@(posedge wr_clk)
        rst |=> !wr_perr);

    assert_wr_flag_R5: assert property (@(posedge wr_clk) disable iff (rst)
        wr_go |=> wr_perr == ((^$past(wr_data)) ^ $past(odd_sel)));

    assert_wr_flag_hold_R5: assert property (@(posedge wr_clk) disable iff (rst)
        !wr_go && addr_seen |=> $stable(wr_perr));

    assert_no_access_hold_R2: assert property (@(posedge rd_clk) disable iff (rst)
        !pipe_mode && !rd_go |=> pipe_mode || ($stable(rd_data) && $stable(rd_perr)));

    assert_rd_flag_align_R6: assert property (@(posedge rd_clk) disable iff (rst)
        !pipe_mode && rd_go |=> pipe_mode || (rd_perr == ((^rd_data) ^ $past(odd_sel))));

    assert_pipe_delay_R4: assert property (@(posedge rd_clk) disable iff (rst)
        pipe_mode |=> !pipe_mode ||
            ((rd_data == $past(s1_data)) && (rd_perr == $past(s1_perr))));
endmodule

bind dual_clk_parity_ram dcpr_checker #(.AW(AW), .DW(DW)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .odd_sel   (odd_sel),
    .pipe_mode (pipe_mode),
    .wr_sel_n  (wr_sel_n),
    .wr_stb_n  (wr_stb_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_perr   (wr_perr),
    .rd_sel_n  (rd_sel_n),
    .rd_stb_n  (rd_stb_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_perr   (rd_perr),
    .s1_data   (s1_data),
    .s1_perr   (s1_perr)
);

// File: tb/dual_clk_parity_ram_bench.sv
`timescale 1ns/1ps
module dual_clk_parity_ram_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       odd_sel = 1'b0;
    logic       pipe_mode = 1'b0;
    logic       wr_sel_n = 1'b1;
    logic       wr_stb_n = 1'b1;
    logic [7:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic       wr_perr;
    logic       rd_sel_n = 1'b1;
    logic       rd_stb_n = 1'b1;
    logic [7:0] rd_addr = '0;
    logic [8:0] rd_data;
    logic       rd_perr;

    always #2 clk = ~clk;

    dual_clk_parity_ram u_dual_clk_parity_ram (
        .wr_clk    (clk),
        .rd_clk    (clk),
        .rst       (rst),
        .odd_sel   (odd_sel),
        .pipe_mode (pipe_mode),
        .wr_sel_n  (wr_sel_n),
        .wr_stb_n  (wr_stb_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_perr   (wr_perr),
        .rd_sel_n  (rd_sel_n),
        .rd_stb_n  (rd_stb_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_perr   (rd_perr)
    );

    logic [8:0] shadow [256];
    logic [8:0] e_s1 = '0, e_s2 = '0;
    logic       e_p1 = 1'b0, e_p2 = 1'b0, e_wp = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    function automatic logic perr_of(input logic [8:0] w, input logic odd);
        return (^w) ^ odd;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance one edge, update the model from the driven inputs, compare after the edge.
    task automatic tick(input string tag);
        logic we, re;
        logic [8:0] nw;
        @(posedge clk);
        we = !wr_sel_n && !wr_stb_n;
        re = !rd_sel_n && !rd_stb_n;
        if (rst) begin
            e_s1 = '0; e_p1 = 1'b0; e_s2 = '0; e_p2 = 1'b0; e_wp = 1'b0;
        end else begin
            e_s2 = e_s1; e_p2 = e_p1;
            if (re) begin
                nw   = (we && wr_addr == rd_addr) ? wr_data : shadow[rd_addr];
                e_s1 = nw;
                e_p1 = perr_of(nw, odd_sel);
            end
            if (we) e_wp = perr_of(wr_data, odd_sel);
        end
        if (we) shadow[wr_addr] = wr_data;
        @(negedge clk);
        cmp(tag, "rd_data", int'(rd_data), int'(pipe_mode ? e_s2 : e_s1));
        cmp(rst ? "R8" : "R6", "rd_perr", int'(rd_perr), int'(pipe_mode ? e_p2 : e_p1));
        cmp(rst ? "R8" : "R5", "wr_perr", int'(wr_perr), int'(e_wp));
    endtask

    task automatic set_wr(input logic s, input logic t, input logic [7:0] a, input logic [8:0] d);
        wr_sel_n = s; wr_stb_n = t; wr_addr = a; wr_data = d;
    endtask

    task automatic set_rd(input logic s, input logic t, input logic [7:0] a);
        rd_sel_n = s; rd_stb_n = t; rd_addr = a;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset state
        repeat (3) tick("R8");
        rst = 1'b0;

        // Fill every word so reads never meet unwritten storage (R1).
        for (int a = 0; a < 256; a++) begin
            set_wr(1'b0, 1'b0, 8'(a), 9'($urandom));
            odd_sel = 1'($urandom);
            tick("R1");
        end
        set_wr(1'b1, 1'b1, 8'd0, 9'd0);

        // R1: blocked writes leave the stored word intact.
        set_wr(1'b0, 1'b0, 8'd5, 9'h0A5); tick("R1");
        set_wr(1'b1, 1'b0, 8'd5, 9'h15A); tick("R1");
        set_wr(1'b0, 1'b1, 8'd5, 9'h1FF); tick("R1");
        set_wr(1'b1, 1'b1, 8'd0, 9'd0);
        set_rd(1'b0, 1'b0, 8'd5); tick("R1");
        cmp("R1", "blocked write readback", int'(rd_data), 32'h0A5);

        // R3: flow-through read, R5 bad parity in both polarities.
        odd_sel = 1'b1;
        set_wr(1'b0, 1'b0, 8'd9, 9'h001); set_rd(1'b0, 1'b0, 8'd6); tick("R3");
        cmp("R5", "odd good parity", int'(wr_perr), 0);
        set_wr(1'b0, 1'b0, 8'd9, 9'h003); tick("R3");
        cmp("R5", "odd bad parity", int'(wr_perr), 1);
        odd_sel = 1'b0;
        set_wr(1'b0, 1'b0, 8'd10, 9'h003); tick("R3");
        cmp("R5", "even good parity", int'(wr_perr), 0);
        set_wr(1'b1, 1'b1, 8'd0, 9'd0);
        set_rd(1'b0, 1'b0, 8'd9); tick("R3");
        cmp("R5", "bad word still stored", int'(rd_data), 32'h003);

        // R2: no access started, output holds while address moves.
        set_rd(1'b1, 1'b0, 8'd10); tick("R2");
        set_rd(1'b0, 1'b1, 8'd11); tick("R2");
        cmp("R2", "hold after blocked read", int'(rd_data), 32'h003);

        // R7: same-address collision in both latency modes.
        set_wr(1'b0, 1'b0, 8'd20, 9'h1C3); set_rd(1'b0, 1'b0, 8'd20); tick("R7");
        cmp("R7", "write-through flow", int'(rd_data), 32'h1C3);
        pipe_mode = 1'b1;
        set_wr(1'b0, 1'b0, 8'd20, 9'h03C); tick("R7");
        set_wr(1'b1, 1'b1, 8'd0, 9'd0); set_rd(1'b1, 1'b1, 8'd0); tick("R4");
        cmp("R7", "write-through piped", int'(rd_data), 32'h03C);

        // R4: pipelined latency of two edges.
        set_rd(1'b0, 1'b0, 8'd5); tick("R4");
        set_rd(1'b1, 1'b1, 8'd0); tick("R4");
        cmp("R4", "piped read second edge", int'(rd_data), 32'h0A5);
        pipe_mode = 1'b0;

        // Random traffic, addresses mostly in a narrow window.
        for (int i = 0; i < 4000; i++) begin
            logic re, wc;
            logic [7:0] ra, wa;
            ra = ($urandom % 4 != 0) ? 8'($urandom % 8) : 8'($urandom);
            wa = ($urandom % 4 != 0) ? 8'($urandom % 8) : 8'($urandom);
            set_wr(1'($urandom % 4 == 0), 1'($urandom % 5 == 0), wa, 9'($urandom));
            set_rd(1'($urandom % 4 == 0), 1'($urandom % 5 == 0), ra);
            if ($urandom % 50 == 0) pipe_mode = ~pipe_mode;
            if ($urandom % 20 == 0) odd_sel = ~odd_sel;
            rst = ($urandom % 300 == 0);
            re = !rd_sel_n && !rd_stb_n;
            wc = !wr_sel_n && !wr_stb_n && re && (wr_addr == rd_addr);
            tick(rst ? "R8" : wc ? "R7" : !re ? "R2" : pipe_mode ? "R4" : "R3");
        end
        rst = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule